// File: doc/BRIEF.md
# Masked Broadcast-Memory Write Distributor

This block takes one stream of host-side write packets and fans its payload out to the local memories of a set of processing blocks. A packet opens with four header words: a payload length, a start address, a block number and a block mask. The payload words follow the header. Each payload word is written at the next consecutive address of every block that the header selects.

Selection compares the block index with the block number on every bit the mask leaves clear. One packet can therefore reach a single block, any aligned group of blocks, or all of them. Each block has its own registered write port with an enable, an address and a data word. Upstream logic uses a valid/ready handshake and keeps instruction traffic on a separate path.

Top module: `bcastWriteDist`

## Requirements
- R1: While reset is held and in the first cycle after its release, every write enable is low and `inReady` is high.
- R2: Header words arrive in a fixed order: length, start address, block number, block mask. Each field is taken from the low bits of its own input word.
- R3: After the mask word is accepted, `inReady` is low for exactly one cycle and then returns high.
- R4: Block k is written when `(k & ~mask) == (blockNum & ~mask)`. All blocks selected by one packet receive the same address and data, and unselected blocks see no enable.
- R5: Payload word i of a packet goes to address `start + i`, modulo 2^ADDR_W.
- R6: A packet of length L causes exactly L writes per selected block. The word accepted after the last payload word is treated as the next packet's length word.
- R7: A packet of length zero writes nothing. The next input word is the next packet's length word.
- R8: A payload word accepted on clock edge t appears on the selected write ports, with enable high, in the cycle after edge t.
- R9: A payload cycle with `inValid` low produces no write, and the address does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input word valid |
| inReady | output | 1 | Block accepts the word this cycle |
| inData | input | DATA_W | Header or payload word |
| wrEnOut | output | NUM_BLK | Per-block write enable |
| wrAddrOut | output | NUM_BLK*ADDR_W | Per-block write address, block k in slice k |
| wrDataOut | output | NUM_BLK*DATA_W | Per-block write data, block k in slice k |

## Verification
The bench uses the default 16 blocks, an 8-bit address and 32-bit data. The 8-bit address makes a wrap at 256 reachable with a short packet. The 16 blocks allow masks of every alignment, from a single block up to all of them. Random packets with random idle gaps are mixed with directed cases: zero length, the all-ones mask, and a start address just below the wrap.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
  typedef enum logic [2:0] {
    ST_LEN, ST_ADDR, ST_BLK, ST_MASK, ST_DECODE, ST_PAYLOAD
  } bwdState_t;

  typedef struct packed {
    logic capLen;
    logic capAddr;
    logic capBlk;
    logic capMask;
    logic decode;
    logic writeWord;
  } bwdStrobe_t;
endpackage

// File: rtl/bwd_ctrl.sv
module bwd_ctrl
  import bwd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inValid,
  input  logic       lenZero,
  input  logic       lastWord,
  output logic       inReady,
  output bwdStrobe_t strobe
);
  bwdState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_LEN;
    else        state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    inReady   = (state != ST_DECODE);
    unique case (state)
      ST_LEN:     if (inValid) begin strobe.capLen  = 1'b1; stateNext = ST_ADDR; end
      ST_ADDR:    if (inValid) begin strobe.capAddr = 1'b1; stateNext = ST_BLK;  end
      ST_BLK:     if (inValid) begin strobe.capBlk  = 1'b1; stateNext = ST_MASK; end
      ST_MASK:    if (inValid) begin strobe.capMask = 1'b1; stateNext = ST_DECODE; end
      ST_DECODE: begin
        strobe.decode = 1'b1;
        stateNext = lenZero ? ST_LEN : ST_PAYLOAD;
      end
      ST_PAYLOAD: if (inValid) begin
        strobe.writeWord = 1'b1;
        if (lastWord) stateNext = ST_LEN;
      end
      default: stateNext = ST_LEN;
    endcase
  end
endmodule

// File: rtl/bwd_datapath.sv
module bwd_datapath
  import bwd_pkg::*;
#(
  parameter int NUM_BLK = 16,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int LEN_W   = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [DATA_W-1:0]         inData,
  input  bwdStrobe_t                strobe,
  output logic                      lenZero,
  output logic                      lastWord,
  output logic [NUM_BLK-1:0]        wrEnOut,
  output logic [NUM_BLK*ADDR_W-1:0] wrAddrOut,
  output logic [NUM_BLK*DATA_W-1:0] wrDataOut
);
  localparam int BLK_W = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1;

  logic [LEN_W-1:0]   lenReg, remCnt;
  logic [ADDR_W-1:0]  addrCnt;
  logic [BLK_W-1:0]   blkReg, maskReg;
  logic [NUM_BLK-1:0] selComb, selReg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lenReg  <= '0;
      remCnt  <= '0;
      addrCnt <= '0;
      blkReg  <= '0;
      maskReg <= '0;
      selReg  <= '0;
    end else begin
      if (strobe.capLen)  lenReg  <= inData[LEN_W-1:0];
      if (strobe.capAddr) addrCnt <= inData[ADDR_W-1:0];
      if (strobe.capBlk)  blkReg  <= inData[BLK_W-1:0];
      if (strobe.capMask) maskReg <= inData[BLK_W-1:0];
      if (strobe.decode) begin
        selReg <= selComb;
        remCnt <= lenReg;
      end
      if (strobe.writeWord) begin
        addrCnt <= addrCnt + 1'b1;
        remCnt  <= remCnt - 1'b1;
      end
    end
  end

  assign lenZero  = (lenReg == '0);
  assign lastWord = (remCnt == LEN_W'(1));

  for (genvar k = 0; k < NUM_BLK; k++) begin : g_blk
    assign selComb[k] = ((BLK_W'(k) & ~maskReg) == (blkReg & ~maskReg));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wrEnOut[k]                      <= 1'b0;
        wrAddrOut[k*ADDR_W +: ADDR_W]   <= '0;
        wrDataOut[k*DATA_W +: DATA_W]   <= '0;
      end else begin
        wrEnOut[k] <= strobe.writeWord & selReg[k];
        if (strobe.writeWord && selReg[k]) begin
          wrAddrOut[k*ADDR_W +: ADDR_W] <= addrCnt;
          wrDataOut[k*DATA_W +: DATA_W] <= inData;
        end
      end
    end
  end
endmodule

// File: rtl/bcastWriteDist.sv
module bcastWriteDist
  import bwd_pkg::*;
#(
  parameter int NUM_BLK = 16,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int LEN_W   = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      inValid,
  output logic                      inReady,
  input  logic [DATA_W-1:0]         inData,
  output logic [NUM_BLK-1:0]        wrEnOut,
  output logic [NUM_BLK*ADDR_W-1:0] wrAddrOut,
  output logic [NUM_BLK*DATA_W-1:0] wrDataOut
);
  bwdStrobe_t strobe;
  logic       lenZero, lastWord;

  bwd_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid),
    .lenZero(lenZero), .lastWord(lastWord),
    .inReady(inReady), .strobe(strobe)
  );

  bwd_datapath #(
    .NUM_BLK(NUM_BLK), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .inData(inData), .strobe(strobe),
    .lenZero(lenZero), .lastWord(lastWord),
    .wrEnOut(wrEnOut), .wrAddrOut(wrAddrOut), .wrDataOut(wrDataOut)
  );
endmodule

// File: rtl/bwd_checker.sv
module bwd_checker #(
  parameter int NUM_BLK = 16,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      inValid,
  input logic                      inReady,
  input logic [NUM_BLK-1:0]        wrEnOut,
  input logic [NUM_BLK*ADDR_W-1:0] wrAddrOut
);
  // R3
  ready_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(inReady) |=> inReady);

  // R8
  write_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|wrEnOut) |-> $past(inValid && inReady));

  // R4
  stable_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|wrEnOut) && $past(|wrEnOut)) |-> (wrEnOut == $past(wrEnOut)));

  // R9
  stall_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inValid && inReady) |=> (wrEnOut == '0));

  for (genvar k = 0; k < NUM_BLK; k++) begin : g_adr
    // R5
    consec_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wrEnOut[k] && $past(wrEnOut[k])) |->
        (wrAddrOut[k*ADDR_W +: ADDR_W] == $past(wrAddrOut[k*ADDR_W +: ADDR_W]) + 1'b1));
  end
endmodule

bind bcastWriteDist bwd_checker #(
  .NUM_BLK(NUM_BLK), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_bwd_checker (
  .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady),
  .wrEnOut(wrEnOut), .wrAddrOut(wrAddrOut)
);

// File: tb/bcastWriteDist_test.sv
module bcastWriteDist_test;
  localparam int NUM_BLK = 16;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam int LEN_W   = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0;
  logic inReady;
  logic [DATA_W-1:0] inData = '0;
  logic [NUM_BLK-1:0] wrEnOut;
  logic [NUM_BLK*ADDR_W-1:0] wrAddrOut;
  logic [NUM_BLK*DATA_W-1:0] wrDataOut;

  always #2 clk = ~clk;

  bcastWriteDist #(.NUM_BLK(NUM_BLK), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) uut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady), .inData(inData),
    .wrEnOut(wrEnOut), .wrAddrOut(wrAddrOut), .wrDataOut(wrDataOut)
  );

  typedef struct {
    logic [NUM_BLK-1:0] en;
    logic [ADDR_W-1:0]  addr;
    logic [DATA_W-1:0]  data;
    int                 cyc;
  } expWr_t;

  expWr_t expQ[$];
  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always @(posedge clk) cyc++;

  function automatic logic [NUM_BLK-1:0] expSel(input int blk, input int mask);
    logic [NUM_BLK-1:0] s;
    for (int k = 0; k < NUM_BLK; k++)
      s[k] = ((k & ~mask & (NUM_BLK-1)) == (blk & ~mask & (NUM_BLK-1)));
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input string msg,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, msg, act, exp);
    end
  endtask

  // Drive one word and wait until it is accepted; returns acceptance cycle.
  task automatic sendWord(input logic [DATA_W-1:0] w, output int accCyc);
    inValid = 1'b1;
    inData  = w;
    while (!inReady) @(negedge clk);
    accCyc = cyc + 1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic sendPacket(input int len, input int start, input int blk,
                            input int mask, input int gapPct);
    int a;
    logic [NUM_BLK-1:0] sel;
    logic [DATA_W-1:0] w;
    sel = expSel(blk, mask);
    // R2: header order length, address, block number, mask
    sendWord(DATA_W'(len), a);
    sendWord(DATA_W'(start), a);
    sendWord(DATA_W'(blk), a);
    sendWord(DATA_W'(mask), a);
    // R3: one decode cycle with ready low, then high
    check(inReady == 1'b0, "R3", "ready during decode", inReady, 0);
    @(negedge clk);
    check(inReady == 1'b1, "R3", "ready after decode", inReady, 1);
    for (int i = 0; i < len; i++) begin
      // R9: idle gaps inside the payload
      while (($urandom % 100) < gapPct) @(negedge clk);
      w = $urandom;
      sendWord(w, a);
      expQ.push_back('{en: sel, addr: ADDR_W'(start + i), data: w, cyc: a});
    end
  endtask

  // Monitor: every write must match the expected queue head (R4, R5, R6, R8)
  always @(negedge clk) begin
    if (rst_n && (wrEnOut != '0)) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R6", "write without pending payload word", wrEnOut, 0);
      end else begin
        expWr_t e;
        e = expQ.pop_front();
        check(wrEnOut == e.en, "R4", "enable pattern", wrEnOut, e.en);
        check(cyc == e.cyc, "R8", "write cycle", cyc, e.cyc);
        for (int k = 0; k < NUM_BLK; k++) begin
          if (e.en[k]) begin
            check(wrAddrOut[k*ADDR_W +: ADDR_W] == e.addr, "R5", "address",
                  wrAddrOut[k*ADDR_W +: ADDR_W], e.addr);
            check(wrDataOut[k*DATA_W +: DATA_W] == e.data, "R4", "data",
                  wrDataOut[k*DATA_W +: DATA_W], e.data);
          end
        end
      end
    end
  end

  task automatic drain(input string req);
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, req, "missing writes", expQ.size(), 0);
    expQ.delete();
  endtask

  task automatic finish();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      finish();
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(wrEnOut == '0, "R1", "enables in reset", wrEnOut, 0);
    check(inReady == 1'b1, "R1", "ready in reset", inReady, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(wrEnOut == '0, "R1", "enables after reset", wrEnOut, 0);
    check(inReady == 1'b1, "R1", "ready after reset", inReady, 1);

    // R4: all-ones mask selects every block
    sendPacket(4, 10, 3, 15, 0);
    drain("R6");
    // R4: zero mask selects only the numbered block
    sendPacket(3, 0, 9, 0, 0);
    drain("R6");
    // R7: zero length then a normal packet directly after
    sendPacket(0, 5, 2, 3, 0);
    repeat (3) @(negedge clk);
    check(wrEnOut == '0, "R7", "zero-length packet wrote", wrEnOut, 0);
    sendPacket(2, 40, 6, 3, 0);
    drain("R7");
    // R5: address wrap modulo 2^ADDR_W
    sendPacket(5, 254, 12, 7, 0);
    drain("R5");
    // R9: payload with heavy idle gaps
    sendPacket(8, 100, 1, 1, 60);
    drain("R9");
    // R6: back-to-back packets, random fields
    for (int p = 0; p < 40; p++) begin
      sendPacket($urandom % 20, $urandom % 256, $urandom % 16, $urandom % 16, $urandom % 40);
    end
    drain("R6");
    finished = 1'b1;
    finish();
  end
endmodule